// File: doc/BRIEF.md
# Serial Byte Transmitter with Clear-to-Send Gating

This block turns single bytes into asynchronous serial frames on one output line. A producer raises a write request with a byte beside it. The transmitter takes the byte on the first clock where it is idle and allowed to start. It then drives a low start bit, the eight data bits least significant first, and a high stop bit. Each bit lasts as many clocks as the baud divisor gives. A busy flag tells the producer when the next byte can be offered.

Before each frame begins, the transmitter looks at an active-low clear-to-send input, which is first brought through a synchronizer. While the far end holds that input high, a pending request waits and the line stays idle. A frame that has already started always runs to completion. A run-time disable input makes the transmitter ignore clear-to-send. A build-time parameter can remove the gating logic altogether.

Top module: `ser_tx_flow`

## Requirements
- R1: After reset, and whenever no frame is in progress, `tx_line` is high and `busy` is low.
- R2: A frame is one low start bit, then `wr_byte[0]` through `wr_byte[7]` in that order, then one high stop bit.
- R3: Every bit lasts exactly `baud_div` clocks, and a divisor of 0 counts as 1. The divisor is captured at acceptance, so a later change does not alter a frame in progress.
- R4: A byte is accepted at the clock edge where `wr_req` is high, `busy` is low and starting is allowed. `wr_byte` is ignored at every other time, including while a frame runs.
- R5: `busy` rises at the acceptance edge and falls exactly 10 bit times later, with the line high at that point.
- R6: With gating built in and `flow_off` low, a high synchronized `cts_n` keeps a pending request from starting. `busy` stays low and the line stays high.
- R7: `cts_n` goes through a two-flop synchronizer. Once `cts_n` falls while `wr_req` is held high, the frame starts at the third rising clock edge.
- R8: A change of `cts_n` during a frame has no effect on that frame.
- R9: While `flow_off` is high, `cts_n` is ignored and a request starts at the next edge.
- R10: With the build parameter `FLOW_EN` set to 0, both `cts_n` and `flow_off` are ignored, and requests start exactly as they would with flow control disabled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_req | input | 1 | Transmit request; held high until `busy` rises |
| wr_byte | input | DATA_W | Byte to send, sampled only on acceptance |
| cts_n | input | 1 | Clear-to-send from the far end, active low, asynchronous |
| flow_off | input | 1 | Run-time disable for clear-to-send gating |
| baud_div | input | DIV_W | Clocks per bit (0 is treated as 1) |
| tx_line | output | 1 | Serial output line, idles high |
| busy | output | 1 | High while a frame is in progress |

## Verification
Two decisions can fall on the same clock edge: the synchronized clear-to-send becoming permissive, and the acceptance of a request that has been waiting. The bench holds `wr_req` high with `cts_n` blocked, then releases `cts_n` at one falling edge. It checks that `busy` is still low after the first and second rising edges and high after the third. It also raises `cts_n` immediately after acceptance, and changes the divisor and the data at the same time, to confirm that the running frame keeps its captured byte, timing and shape.

// File: rtl/ser_tx_pkg.sv
package ser_tx_pkg;
   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_START = 2'd1,
      ST_DATA  = 2'd2,
      ST_STOP  = 2'd3
   } tx_state_e;
endpackage

// File: rtl/ser_cts_sync.sv
module ser_cts_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst,
   input  logic cts_n_in,
   output logic cts_n_sync
);
   if (STAGES < 2) begin : g_bad_stages
      $error("ser_cts_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain;

   always_ff @(posedge clk) begin
      if (rst) chain <= '1;
      else     chain <= {chain[STAGES-2:0], cts_n_in};
   end

   assign cts_n_sync = chain[STAGES-1];
endmodule

// File: rtl/ser_bit_timer.sv
module ser_bit_timer #(
   parameter int DIV_W = 16
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             restart,
   input  logic             run,
   input  logic [DIV_W-1:0] div_in,
   output logic             bit_end
);
   if (DIV_W < 1) begin : g_bad_div
      $error("ser_bit_timer: DIV_W must be positive");
   end

   logic [DIV_W-1:0] div_lat;
   logic [DIV_W-1:0] cnt;
   logic             last_clk;

   assign last_clk = (cnt == div_lat - 1'b1);
   assign bit_end  = run && last_clk;

   always_ff @(posedge clk) begin
      if (rst) begin
         div_lat <= DIV_W'(1);
         cnt     <= '0;
      end else if (restart) begin
         div_lat <= (div_in == '0) ? DIV_W'(1) : div_in;
         cnt     <= '0;
      end else if (run) begin
         cnt <= last_clk ? '0 : cnt + 1'b1;
      end
   end

   // R3: the bit counter never passes the captured divisor
   p_cnt_in_range_r3: assert property (@(posedge clk) disable iff (rst)
      run |-> (cnt < div_lat));
   // R3: the divisor only changes at a restart
   p_div_held_r3: assert property (@(posedge clk) disable iff (rst)
      !restart |=> $stable(div_lat));
endmodule

// File: rtl/ser_frame.sv
module ser_frame
   import ser_tx_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              go,
   input  logic [DATA_W-1:0] data_in,
   input  logic              bit_end,
   output logic              line,
   output logic              active
);
   localparam int IDX_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DATA_W - 1);

   if (DATA_W < 2) begin : g_bad_width
      $error("ser_frame: DATA_W must be at least 2");
   end

   tx_state_e         state;
   logic [DATA_W-1:0] shreg;
   logic [IDX_W-1:0]  idx;

   assign active = (state != ST_IDLE);

   always_ff @(posedge clk) begin
      if (rst) begin
         state <= ST_IDLE;
         line  <= 1'b1;
         shreg <= '0;
         idx   <= '0;
      end else begin
         case (state)
            ST_IDLE: if (go) begin
               state <= ST_START;
               line  <= 1'b0;
               shreg <= data_in;
            end
            ST_START: if (bit_end) begin
               state <= ST_DATA;
               line  <= shreg[0];
               shreg <= shreg >> 1;
               idx   <= '0;
            end
            ST_DATA: if (bit_end) begin
               if (idx == LAST_IDX) begin
                  state <= ST_STOP;
                  line  <= 1'b1;
               end else begin
                  line  <= shreg[0];
                  shreg <= shreg >> 1;
                  idx   <= idx + 1'b1;
               end
            end
            ST_STOP: if (bit_end) state <= ST_IDLE;
            default: state <= ST_IDLE;
         endcase
      end
   end

   // R1: an idle transmitter holds the line high
   p_idle_high_r1: assert property (@(posedge clk) disable iff (rst)
      !active |-> line);
   // R2: a frame opens with a low start bit
   p_start_low_r2: assert property (@(posedge clk) disable iff (rst)
      $rose(active) |-> !line);
   // R5: the stop bit is high and leaves the line high
   p_stop_high_r5: assert property (@(posedge clk) disable iff (rst)
      $fell(active) |-> (line && $past(line)));
endmodule

// File: rtl/ser_tx_flow.sv
module ser_tx_flow #(
   parameter int DATA_W      = 8,
   parameter int DIV_W       = 16,
   parameter bit FLOW_EN     = 1'b1,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              wr_req,
   input  logic [DATA_W-1:0] wr_byte,
   input  logic              cts_n,
   input  logic              flow_off,
   input  logic [DIV_W-1:0]  baud_div,
   output logic              tx_line,
   output logic              busy
);
   logic clear;
   logic go;
   logic bit_end;

   if (FLOW_EN) begin : g_flow
      logic cts_sync;
      logic [1:0] age;

      ser_cts_sync #(.STAGES(SYNC_STAGES)) u_sync (
         .clk        (clk),
         .rst        (rst),
         .cts_n_in   (cts_n),
         .cts_n_sync (cts_sync)
      );
      assign clear = flow_off | ~cts_sync;

      always_ff @(posedge clk) begin
         if (rst)               age <= '0;
         else if (age != 2'd3)  age <= age + 1'b1;
      end

      if (SYNC_STAGES == 2) begin : g_chk_sync
         // R7: gating uses clear-to-send as it was two edges earlier
         p_sync_delay_r7: assert property (@(posedge clk) disable iff (rst)
            (age == 2'd3) |-> (cts_sync == $past(cts_n, 2)));
      end
   end else begin : g_noflow
      logic unused_flow;
      assign unused_flow = cts_n ^ flow_off;
      assign clear = 1'b1;
   end

   assign go = wr_req & ~busy & clear;

   ser_bit_timer #(.DIV_W(DIV_W)) u_timer (
      .clk     (clk),
      .rst     (rst),
      .restart (go),
      .run     (busy),
      .div_in  (baud_div),
      .bit_end (bit_end)
   );

   ser_frame #(.DATA_W(DATA_W)) u_frame (
      .clk     (clk),
      .rst     (rst),
      .go      (go),
      .data_in (wr_byte),
      .bit_end (bit_end),
      .line    (tx_line),
      .active  (busy)
   );

   // R4: a permitted request starts a frame on the next edge
   p_accept_r4: assert property (@(posedge clk) disable iff (rst)
      (wr_req && !busy && clear) |=> busy);
   // R6: a blocked request leaves the transmitter idle
   p_blocked_r6: assert property (@(posedge clk) disable iff (rst)
      (!busy && !clear) |=> !busy);
endmodule

// File: tb/tb_ser_tx_flow.sv
module tb_ser_tx_flow;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        wr_a = 1'b0, wr_b = 1'b0;
   logic [7:0]  wr_byte = 8'h00;
   logic        cts_n = 1'b0;
   logic        flow_off = 1'b0;
   logic [15:0] baud_div = 16'd4;
   logic        line_a, busy_a, line_b, busy_b;
   int          n_checks = 0;
   int          n_fail = 0;
   int          cycles = 0;

   always #10 clk = ~clk;

   ser_tx_flow dut (
      .clk(clk), .rst(rst), .wr_req(wr_a), .wr_byte(wr_byte), .cts_n(cts_n),
      .flow_off(flow_off), .baud_div(baud_div), .tx_line(line_a), .busy(busy_a)
   );

   ser_tx_flow #(.FLOW_EN(1'b0)) dut_nf (
      .clk(clk), .rst(rst), .wr_req(wr_b), .wr_byte(wr_byte), .cts_n(cts_n),
      .flow_off(flow_off), .baud_div(baud_div), .tx_line(line_b), .busy(busy_b)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
      end
   endtask

   task automatic finish_up();
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   endtask

   function automatic logic get_line(input bit nf);
      return nf ? line_b : line_a;
   endfunction

   function automatic logic get_busy(input bit nf);
      return nf ? busy_b : busy_a;
   endfunction

   // Called at the falling edge just after acceptance; returns at the
   // falling edge after the frame ends.
   task automatic check_frame(input bit nf, input logic [7:0] data, input int d);
      for (int n = 0; n < 10 * d; n++) begin
         int k = n / d;
         logic exp;
         exp = (k == 0) ? 1'b0 : (k == 9) ? 1'b1 : data[k-1];
         if ((n % d) == 0 || (n % d) == d - 1) begin
            check(get_line(nf) == exp, "R2 R3 bit value", get_line(nf), exp);
            check(get_busy(nf) == 1'b1, "R5 busy in frame", get_busy(nf), 1);
         end
         @(negedge clk);
      end
      check(get_busy(nf) == 1'b0, "R5 busy after stop", get_busy(nf), 0);
      check(get_line(nf) == 1'b1, "R1 line idle after frame", get_line(nf), 1);
   endtask

   task automatic send(input bit nf, input logic [7:0] data, input int d_in, input int d_eff);
      @(negedge clk);
      baud_div = 16'(d_in);
      wr_byte  = data;
      if (nf) wr_b = 1'b1; else wr_a = 1'b1;
      @(negedge clk);
      check(get_busy(nf) == 1'b1, "R4 accepted", get_busy(nf), 1);
      wr_a = 1'b0; wr_b = 1'b0;
      wr_byte  = ~data;          // R4: ignored while busy
      baud_div = 16'd7;          // R3: divisor captured at acceptance
      check_frame(nf, data, d_eff);
   endtask

   task automatic t_reset();
      check(line_a == 1'b1 && line_b == 1'b1, "R1 line after reset", {line_a, line_b}, 3);
      check(busy_a == 1'b0 && busy_b == 1'b0, "R1 busy after reset", {busy_a, busy_b}, 0);
   endtask

   task automatic t_basic();
      send(1'b0, 8'hA5, 4, 4);
      send(1'b0, 8'h3C, 1, 1);
      send(1'b0, 8'h81, 0, 1);   // R3 divisor zero acts as one
      send(1'b0, 8'h5E, 3, 3);
   endtask

   task automatic t_blocked_then_release();
      @(negedge clk);
      cts_n = 1'b1; flow_off = 1'b0;
      repeat (4) @(negedge clk);
      baud_div = 16'd2; wr_byte = 8'hC3; wr_a = 1'b1;
      for (int i = 0; i < 12; i++) begin
         @(negedge clk);
         check(busy_a == 1'b0, "R6 blocked busy", busy_a, 0);
         check(line_a == 1'b1, "R6 blocked line", line_a, 1);
      end
      cts_n = 1'b0;
      @(negedge clk);
      check(busy_a == 1'b0, "R7 first edge", busy_a, 0);
      @(negedge clk);
      check(busy_a == 1'b0, "R7 second edge", busy_a, 0);
      @(negedge clk);
      check(busy_a == 1'b1, "R7 third edge start", busy_a, 1);
      wr_a = 1'b0;
      cts_n = 1'b1;              // R8: raised during the frame
      wr_byte = 8'h00;
      check_frame(1'b0, 8'hC3, 2);
      @(negedge clk);
      cts_n = 1'b0;
   endtask

   task automatic t_flow_off();
      @(negedge clk);
      cts_n = 1'b1; flow_off = 1'b1;
      repeat (3) @(negedge clk);
      send(1'b0, 8'h69, 3, 3);   // R9
      flow_off = 1'b0; cts_n = 1'b0;
   endtask

   task automatic t_no_flow_build();
      @(negedge clk);
      cts_n = 1'b1; flow_off = 1'b0;
      repeat (3) @(negedge clk);
      send(1'b1, 8'h96, 2, 2);   // R10
      check(busy_a == 1'b0, "R10 gated twin stays idle", busy_a, 0);
      cts_n = 1'b0;
   endtask

   initial begin
      forever begin
         @(posedge clk);
         cycles++;
         if (cycles > 100000) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", cycles, 100000);
            finish_up();
         end
      end
   end

   initial begin
      repeat (5) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      t_reset();
      t_basic();
      t_blocked_then_release();
      t_flow_off();
      t_no_flow_build();
      repeat (3) @(negedge clk);
      finish_up();
   end
endmodule